// File: doc/BRIEF.md
# Self-Stabilizing Shortest-Path Engine

This engine takes a small weighted directed graph held in an internal weight array and works out, for every node, the cheapest route cost to node 0 (the sink) and the neighbour to step to first. It relaxes the nodes in sweeps, using Gauss-Seidel order: a node updated earlier in a sweep is seen with its new value by the nodes after it. The run ends only when two sweeps in a row leave every distance unchanged.

The distance vector, the next-hop table and the two multi-bit convergence flags can all be overwritten through one write port at any time, including during a run. A test harness uses this to place the engine in an arbitrary state and then observe that it settles to a correct answer. A pulse on `start_i` launches a run. `busy_o` stays high while the run is in progress, and `done_o` pulses for one cycle when it ends. The results are read combinationally by node number.

Top module: `ssp_engine`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low. Every weight and every distance holds 255 (no edge / unreachable), and every next hop is 0.
- R2: A write with `wr_sel_i`=0 stores `wr_data_i` as the weight from node `wr_addr_i[7:4]` to node `wr_addr_i[3:0]`. A write with `wr_sel_i`=1 stores a distance for node `wr_addr_i[3:0]`; the upper address bits are ignored, so node indices wrap modulo 16. A write with `wr_sel_i`=2 loads both convergence flags.
- R3: At the start of every sweep, node 0 gets distance 0 and next hop 0. After a run both still hold these values.
- R4: Within a sweep, each node i from 1 to 15 takes as its distance the minimum over j=0..15 of weight[i][j]+dist[j], and takes the j that gives it as its next hop. Each candidate uses the distances as they stand when that candidate is scanned.
- R5: Candidates are compared with greater-or-equal, scanning j upward from a start value of 255. Among equal sums the highest j wins, so a node where every sum is 255 reports next hop 15.
- R6: The sum weight+distance saturates at 255 instead of wrapping. A node with no finite path reports distance 255.
- R7: Each sweep lasts 241 cycles (one check cycle, then one cycle per matrix entry for nodes 1 to 15). A run of S sweeps raises `done_o` on the (241*S+1)-th rising edge after the edge that accepted `start_i`.
- R8: `done_o` is high for exactly one cycle and only while `busy_o` is low. `start_i` is ignored while `busy_o` is high.
- R9: A start loads both flags with the nonzero pattern 8'hA5, whatever they held before. The run goes on while either flag is nonzero, so even an already settled graph takes two sweeps.
- R10: From any corrupted distance contents, the run ends with the same distances and next hops as a sequential reference loop started from those contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run (taken only when idle) |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 weight, 1 distance, 2 flags |
| wr_addr_i | input | 8 | Weight index {row,col}, or node index in low bits |
| wr_data_i | input | 8 | Write value |
| rd_node_i | input | 4 | Node to read |
| rd_dist_o | output | 8 | Distance of the node being read |
| rd_hop_o | output | 4 | Next hop of the node being read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at run end |

## Verification
If the sweep sequencing or the flag handling goes wrong, the fault shows first in when `done_o` arrives: the bench predicts the exact edge from the reference sweep count, so a single dropped or extra sweep gives an error of 241 cycles. A faulty min/argmin path, tie rule or saturation shows in the distances and next hops read back right after `done_o`. Randomly corrupted starting distances, a cleared-flag start and a start pulse during a run test the self-stabilizing claim and the rule that a second start is ignored.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    SEL_WEIGHT = 2'd0,
    SEL_DIST   = 2'd1,
    SEL_FLAGS  = 2'd2
  } wr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_SCAN  = 2'd2
  } ssp_state_e;

  localparam logic [7:0] FLAG_PATTERN = 8'hA5;
endpackage

// File: rtl/ssp_relax.sv
module ssp_relax #(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic [DW-1:0] weight_i,
  input  logic [DW-1:0] dist_i,
  input  logic [IW-1:0] cand_i,
  input  logic [DW-1:0] min_i,
  input  logic [IW-1:0] arg_i,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] min_o,
  output logic [IW-1:0] arg_o
);
  logic [DW:0] raw;

  always_comb begin
    raw   = {1'b0, weight_i} + {1'b0, dist_i};
    sum_o = raw[DW] ? {DW{1'b1}} : raw[DW-1:0];
    // >= : a later candidate takes ties
    if (min_i >= sum_o) begin
      min_o = sum_o;
      arg_o = cand_i;
    end else begin
      min_o = min_i;
      arg_o = arg_i;
    end
  end
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int NODES = 16,
  parameter int IW    = $clog2(NODES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          flags_set_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          sweep_o,
  output logic          scan_o,
  output logic          node_end_o,
  output logic [IW-1:0] row_o,
  output logic [IW-1:0] col_o
);
  localparam logic [IW-1:0] LAST = IW'(NODES - 1);

  ssp_state_e state_q;
  logic [IW-1:0] row_q, col_q;
  logic done_q;

  assign busy_o     = (state_q != ST_IDLE);
  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign sweep_o    = (state_q == ST_CHECK) && flags_set_i;
  assign scan_o     = (state_q == ST_SCAN);
  assign node_end_o = scan_o && (col_q == LAST);
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_CHECK;
        ST_CHECK: begin
          if (flags_set_i) begin
            state_q <= ST_SCAN;
            row_q   <= IW'(1);
            col_q   <= '0;
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_SCAN: begin
          if (col_q == LAST) begin
            col_q <= '0;
            if (row_q == LAST) state_q <= ST_CHECK;
            else               row_q   <= row_q + IW'(1);
          end else begin
            col_q <= col_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int NODES = 16,
  parameter int DW    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         wr_en_i,
  input  logic [1:0]                   wr_sel_i,
  input  logic [2*$clog2(NODES)-1:0]   wr_addr_i,
  input  logic [DW-1:0]                wr_data_i,
  input  logic [$clog2(NODES)-1:0]     rd_node_i,
  output logic [DW-1:0]                rd_dist_o,
  output logic [$clog2(NODES)-1:0]     rd_hop_o,
  output logic                         busy_o,
  output logic                         done_o
);
  localparam int IW    = $clog2(NODES);
  localparam int AW    = 2 * IW;
  localparam int CELLS = NODES * NODES;
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};
  localparam logic [DW-1:0] FPAT = DW'(FLAG_PATTERN);

  logic [DW-1:0] wt_q   [CELLS];
  logic [DW-1:0] dist_q [NODES];
  logic [IW-1:0] hop_q  [NODES];
  logic [DW-1:0] chg_q, prv_q;
  logic [DW-1:0] min_q;
  logic [IW-1:0] arg_q;

  logic load, sweep, scan, node_end;
  logic [IW-1:0] row, col;
  logic [DW-1:0] sum, min_nxt;
  logic [IW-1:0] arg_nxt;
  logic [IW-1:0] wr_node;
  logic wr_w, wr_d, wr_f;

  assign wr_node = wr_addr_i[IW-1:0];
  assign wr_w    = wr_en_i && (wr_sel_i == SEL_WEIGHT);
  assign wr_d    = wr_en_i && (wr_sel_i == SEL_DIST);
  assign wr_f    = wr_en_i && (wr_sel_i == SEL_FLAGS);

  ssp_seq #(.NODES(NODES), .IW(IW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .flags_set_i ((|chg_q) || (|prv_q)),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .load_o      (load),
    .sweep_o     (sweep),
    .scan_o      (scan),
    .node_end_o  (node_end),
    .row_o       (row),
    .col_o       (col)
  );

  ssp_relax #(.DW(DW), .IW(IW)) u_relax (
    .weight_i (wt_q[{row, col}]),
    .dist_i   (dist_q[col]),
    .cand_i   (col),
    .min_i    (min_q),
    .arg_i    (arg_q),
    .sum_o    (sum),
    .min_o    (min_nxt),
    .arg_o    (arg_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < CELLS; k++) wt_q[k] <= DMAX;
    end else if (wr_w) begin
      wt_q[AW'(wr_addr_i)] <= wr_data_i;
    end
  end

  // port writes override the engine in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NODES; k++) begin
        dist_q[k] <= DMAX;
        hop_q[k]  <= '0;
      end
    end else begin
      if (sweep) begin
        dist_q[0] <= '0;
        hop_q[0]  <= '0;
      end
      if (node_end) begin
        dist_q[row] <= min_nxt;
        hop_q[row]  <= arg_nxt;
      end
      if (wr_d) dist_q[wr_node] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= '0;
      prv_q <= '0;
    end else if (wr_f) begin
      chg_q <= wr_data_i;
      prv_q <= wr_data_i;
    end else if (load) begin
      chg_q <= FPAT;
      prv_q <= FPAT;
    end else if (sweep) begin
      prv_q <= chg_q;
      chg_q <= '0;
    end else if (node_end && (dist_q[row] != min_nxt)) begin
      chg_q <= FPAT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= DMAX;
      arg_q <= '0;
    end else if (sweep || node_end) begin
      min_q <= DMAX;
      arg_q <= '0;
    end else if (scan) begin
      min_q <= min_nxt;
      arg_q <= arg_nxt;
    end
  end

  assign rd_dist_o = dist_q[rd_node_i];
  assign rd_hop_o  = hop_q[rd_node_i];
endmodule

// File: rtl/ssp_engine_chk.sv
module ssp_engine_chk #(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_i,
  input logic          done_i,
  input logic          scan_i,
  input logic [DW-1:0] sink_dist_i,
  input logic [IW-1:0] sink_hop_i,
  input logic [DW-1:0] weight_i,
  input logic [DW-1:0] dist_i,
  input logic [DW-1:0] sum_i,
  input logic [DW-1:0] min_q_i,
  input logic [DW-1:0] min_nxt_i
);
  // R3
  sink_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (sink_dist_i == '0 && sink_hop_i == '0));

  // R4
  min_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_i |-> (min_nxt_i <= min_q_i));

  // R6
  sat_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_i |-> (sum_i >= weight_i && sum_i >= dist_i));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i);
endmodule

bind ssp_engine ssp_engine_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_i      (busy_o),
  .done_i      (done_o),
  .scan_i      (scan),
  .sink_dist_i (dist_q[0]),
  .sink_hop_i  (hop_q[0]),
  .weight_i    (wt_q[{row, col}]),
  .dist_i      (dist_q[col]),
  .sum_i       (sum),
  .min_q_i     (min_q),
  .min_nxt_i   (min_nxt)
);

// File: tb/ssp_engine_test.sv
module ssp_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_addr = 8'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] rd_node = 4'd0;
  logic [7:0] rd_dist;
  logic [3:0] rd_hop;
  logic       busy, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  int tw [256];
  int dm [16];
  int hm [16];

  always #10 clk = ~clk;

  ssp_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_node_i(rd_node), .rd_dist_o(rd_dist), .rd_hop_o(rd_hop),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected under 190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // reference loop; updates the shadow arrays in place
  function automatic int model();
    int b = 8'hA5;
    int c = 8'hA5;
    int sweeps = 0;
    while (b != 0 || c != 0) begin
      c = b;
      b = 0;
      sweeps++;
      dm[0] = 0;
      hm[0] = 0;
      for (int i = 1; i < 16; i++) begin
        int m = 255;
        int a = 0;
        for (int j = 0; j < 16; j++) begin
          int s = tw[i*16+j] + dm[j];
          if (s > 255) s = 255;
          if (m >= s) begin m = s; a = j; end
        end
        if (dm[i] != m) b = 8'hA5;
        dm[i] = m;
        hm[i] = a;
      end
    end
    return sweeps;
  endfunction

  task automatic check_nodes(input string req);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      rd_node = 4'(k);
      #2;
      check(rd_dist == 8'(dm[k]), req, rd_dist, dm[k]);
      check(rd_hop == 4'(hm[k]), req, rd_hop, hm[k]);
    end
  endtask

  // runs engine and model, checks done edge and results
  task automatic run(input string req, input bit poke);
    int n = 0;
    int s;
    s = model();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    do begin
      @(posedge clk);
      n++;
      #1;
      if (poke && n == 100) start = 1'b1;
      else start = 1'b0;
    end while (!done && n < 60000);
    // R7 done edge
    check(n == s*241 + 1, "R7", n, s*241 + 1);
    @(posedge clk);
    #1;
    // R8 single-cycle pulse
    check(!done && !busy, "R8", {30'd0, done, busy}, 0);
    check_nodes(req);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < 256; k++) tw[k] = 255;
    for (int k = 0; k < 16; k++) begin dm[k] = 255; hm[k] = 0; end

    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(!busy && !done, "R1", {30'd0, busy, done}, 0);
    for (int k = 0; k < 16; k++) begin
      rd_node = 4'(k);
      #1;
      check(rd_dist == 8'd255 && rd_hop == 4'd0, "R1", rd_dist, 255);
    end
    rst_n = 1'b1;

    // R2 distance write wraps node index modulo 16
    wr(2'd1, 8'h13, 8'd77);
    dm[3] = 77;
    rd_node = 4'd3;
    #2;
    check(rd_dist == 8'd77, "R2", rd_dist, 77);

    // directed graph: tie (R5), saturation (R6), unreachable
    tw[2*16+0] = 3;  wr(2'd0, 8'h20, 8'd3);
    tw[7*16+0] = 5;  wr(2'd0, 8'h70, 8'd5);
    tw[5*16+2] = 4;  wr(2'd0, 8'h52, 8'd4);
    tw[5*16+7] = 2;  wr(2'd0, 8'h57, 8'd2);
    tw[8*16+0] = 10; wr(2'd0, 8'h80, 8'd10);
    tw[9*16+8] = 250; wr(2'd0, 8'h98, 8'd250);
    run("R4", 1'b0);
    rd_node = 4'd5; #2;
    check(rd_dist == 8'd7 && rd_hop == 4'd7, "R5", rd_hop, 7);
    @(negedge clk); rd_node = 4'd9; #2;
    check(rd_dist == 8'd255, "R6", rd_dist, 255);
    @(negedge clk); rd_node = 4'd11; #2;
    check(rd_dist == 8'd255 && rd_hop == 4'd15, "R6", rd_hop, 15);
    @(negedge clk); rd_node = 4'd0; #2;
    check(rd_dist == 8'd0 && rd_hop == 4'd0, "R3", rd_dist, 0);

    // R9 cleared flags: a settled graph still takes two sweeps
    wr(2'd2, 8'h00, 8'h00);
    run("R9", 1'b0);

    // R10 random graphs from corrupted distances; R8 start during run
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          int w;
          if (i > 0 && j == i - 1) w = 1 + int'($urandom_range(14));
          else if ($urandom_range(99) < 30) w = 1 + int'($urandom_range(14));
          else w = 255;
          tw[i*16+j] = w;
          wr(2'd0, 8'(i*16+j), 8'(w));
        end
      end
      for (int k = 0; k < 16; k++) begin
        int d = int'($urandom_range(255));
        dm[k] = d;
        wr(2'd1, 8'(k), 8'(d));
      end
      run("R10", r == 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule